// File: doc/BRIEF.md
# Eight-Lane Double-Data-Rate Bus Interface

This block sits between a core and an external byte-wide memory bus that moves data on both edges of its clock. On the transmit side the core hands over 16-bit words through a valid/ready handshake. Each word goes out as two bytes on the eight data lines during one external clock period. The external clock is produced as a true/complement pair from registers clocked by an internal clock that runs at twice the external rate.

On the receive side the incoming data lines are sampled by one bank of flip-flops on the rising edge of the receive clock and by a second bank on the falling edge. The byte taken on the falling edge is moved into the rising-edge domain on the next rising edge. The two bytes are then presented together as one 16-bit word with a valid strobe.

The transmitter is a three-state machine: `TX_IDLE`, `TX_HI` and `TX_LO`.

| Transition | Condition |
|---|---|
| `TX_IDLE` → `TX_HI` | word accepted |
| `TX_IDLE` → `TX_IDLE` | no word offered |
| `TX_HI` → `TX_LO` | always |
| `TX_LO` → `TX_HI` | word accepted (back-to-back streaming) |
| `TX_LO` → `TX_IDLE` | no word offered |

The register outputs are decoded from the next state, so the pins change on the same edge as the state register.

Top module: `ddr8_link`

## Requirements
- R1: While `rst_n` is low the block holds `ck_p`=0, `ck_n`=1, `dq_oe`=0, `dq_out`=0, `tx_ready`=1, `rx_valid`=0 and `rx_word`=0.
- R2: `ck_n` is always the complement of `ck_p`.
- R3: A word is accepted on a `clk2x` rising edge where `tx_valid` and `tx_ready` are both 1. From that edge on, for one `clk2x` cycle, `ck_p`=1, `dq_oe`=1 and `dq_out` carries bits [15:8] (the upper byte). For the following cycle `ck_p`=0, `dq_oe`=1 and `dq_out` carries bits [7:0].
- R4: `tx_ready` is 0 exactly in the cycles where `ck_p` is 1, and 1 otherwise.
- R5: With `tx_valid` held high, words are accepted every second `clk2x` cycle and `ck_p` toggles on every `clk2x` edge with no gap.
- R6: When no word is pending, `ck_p` stays 0, `dq_oe` is 0 and `dq_out` is 0.
- R7: The value on `tx_word` has no effect on the pins unless that word is accepted.
- R8: The byte on `dq_in` at a rising edge of `rx_clk` becomes `rx_word[15:8]`. The byte at the following falling edge becomes `rx_word[7:0]`. Both appear together one `rx_clk` cycle later, on the next rising edge.
- R9: `rx_valid` is 1 for the `rx_clk` cycle after the rising edge that assembles a word, and only if `rx_en` was 1 at the rising edge that captured that word's upper byte. While capture stays enabled this gives one word per `rx_clk` cycle.
- R10: `rx_word` holds its value in cycles where `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal transmit clock, twice the external bus rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tx_valid | input | 1 | Core offers a word for transmission |
| tx_word | input | 16 | Word to transmit, upper byte sent first |
| tx_ready | output | 1 | Transmitter can accept a word at the next edge |
| ck_p | output | 1 | External clock, true phase |
| ck_n | output | 1 | External clock, complement phase |
| dq_out | output | 8 | Data lines driven toward the bus |
| dq_oe | output | 1 | Output enable for the data lines |
| rx_clk | input | 1 | Clock returned with incoming data |
| rx_en | input | 1 | Capture enable, sampled on `rx_clk` rising edges |
| dq_in | input | 8 | Data lines received from the bus |
| rx_valid | output | 1 | Assembled receive word is valid this cycle |
| rx_word | output | 16 | Assembled receive word |

## Verification
The bench streams transmit words through bursts, alternating and sparse offers, and drives junk on `tx_word` whenever a word will not be accepted. A design that sent the bytes in the wrong order, stretched the clock between back-to-back words, or latched data while not ready would show a wrong `dq_out` or `ck_p` in a specific cycle. On receive it sweeps all 256 upper-byte values, each paired with a distinct lower byte, and disables capture at scattered cycles. That exposes swapped edge banks, a lower byte taken from the wrong falling edge, a valid strobe one cycle off, or a word that changes while not valid.

// File: rtl/ddr8_pkg.sv
package ddr8_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HI   = 2'd1,
        TX_LO   = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ddr8_tx_fsm.sv
module ddr8_tx_fsm
    import ddr8_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [2*BYTE_W-1:0] tx_word,
    output logic                tx_ready,
    output logic                ck_p,
    output logic                ck_n,
    output logic [BYTE_W-1:0]   dq_out,
    output logic                dq_oe
);
    localparam int WORD_W = 2 * BYTE_W;

    tx_state_e         state_q, state_d;
    logic              accept;
    logic [BYTE_W-1:0] lo_hold;

    // ready in every state except the one driving the upper byte
    assign tx_ready = (state_q != TX_HI);
    assign accept   = tx_valid && tx_ready;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: state_d = accept ? TX_HI : TX_IDLE;
            TX_HI:   state_d = TX_LO;
            TX_LO:   state_d = accept ? TX_HI : TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            ck_p    <= 1'b0;
            ck_n    <= 1'b1;
            dq_out  <= '0;
            dq_oe   <= 1'b0;
            lo_hold <= '0;
        end else begin
            unique case (state_d)
                TX_HI: begin
                    ck_p    <= 1'b1;
                    ck_n    <= 1'b0;
                    dq_out  <= tx_word[WORD_W-1:BYTE_W];
                    dq_oe   <= 1'b1;
                    lo_hold <= tx_word[BYTE_W-1:0];
                end
                TX_LO: begin
                    ck_p   <= 1'b0;
                    ck_n   <= 1'b1;
                    dq_out <= lo_hold;
                    dq_oe  <= 1'b1;
                end
                default: begin
                    ck_p   <= 1'b0;
                    ck_n   <= 1'b1;
                    dq_out <= '0;
                    dq_oe  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ddr8_rx_capture.sv
module ddr8_rx_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              rx_clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [BYTE_W-1:0] dq_in,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              hi_vld
);
    // one rising-edge and one falling-edge flop per data lane
    for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
        always_ff @(posedge rx_clk or negedge rst_n) begin
            if (!rst_n) hi_q[b] <= 1'b0;
            else        hi_q[b] <= dq_in[b];
        end
        always_ff @(negedge rx_clk or negedge rst_n) begin
            if (!rst_n) lo_q[b] <= 1'b0;
            else        lo_q[b] <= dq_in[b];
        end
    end

    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) hi_vld <= 1'b0;
        else        hi_vld <= rx_en;
    end
endmodule

// File: rtl/ddr8_rx_assemble.sv
module ddr8_rx_assemble #(
    parameter int BYTE_W = 8
) (
    input  logic                rx_clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   hi_q,
    input  logic [BYTE_W-1:0]   lo_q,
    input  logic                hi_vld,
    output logic                rx_valid,
    output logic [2*BYTE_W-1:0] rx_word
);
    // falling-edge byte is re-registered here, on the next rising edge
    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= hi_vld;
            if (hi_vld) rx_word <= {hi_q, lo_q};
        end
    end
endmodule

// File: rtl/ddr8_link.sv
module ddr8_link #(
    parameter int BYTE_W = 8
) (
    input  logic                clk2x,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [2*BYTE_W-1:0] tx_word,
    output logic                tx_ready,
    output logic                ck_p,
    output logic                ck_n,
    output logic [BYTE_W-1:0]   dq_out,
    output logic                dq_oe,
    input  logic                rx_clk,
    input  logic                rx_en,
    input  logic [BYTE_W-1:0]   dq_in,
    output logic                rx_valid,
    output logic [2*BYTE_W-1:0] rx_word
);
    logic [BYTE_W-1:0] cap_hi, cap_lo;
    logic              cap_vld;

    ddr8_tx_fsm #(.BYTE_W(BYTE_W)) u_tx (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_word  (tx_word),
        .tx_ready (tx_ready),
        .ck_p     (ck_p),
        .ck_n     (ck_n),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    ddr8_rx_capture #(.BYTE_W(BYTE_W)) u_cap (
        .rx_clk (rx_clk),
        .rst_n  (rst_n),
        .rx_en  (rx_en),
        .dq_in  (dq_in),
        .hi_q   (cap_hi),
        .lo_q   (cap_lo),
        .hi_vld (cap_vld)
    );

    ddr8_rx_assemble #(.BYTE_W(BYTE_W)) u_asm (
        .rx_clk   (rx_clk),
        .rst_n    (rst_n),
        .hi_q     (cap_hi),
        .lo_q     (cap_lo),
        .hi_vld   (cap_vld),
        .rx_valid (rx_valid),
        .rx_word  (rx_word)
    );
endmodule

// File: rtl/ddr8_link_chk.sv
module ddr8_link_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk2x,
    input logic                rst_n,
    input logic                tx_valid,
    input logic [2*BYTE_W-1:0] tx_word,
    input logic                tx_ready,
    input logic                ck_p,
    input logic                ck_n,
    input logic [BYTE_W-1:0]   dq_out,
    input logic                dq_oe,
    input logic                rx_clk,
    input logic                rx_en,
    input logic [BYTE_W-1:0]   dq_in,
    input logic                rx_valid,
    input logic [2*BYTE_W-1:0] rx_word
);
    p_ck_compl_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
        ck_n == !ck_p);

    p_accept_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (ck_p && dq_oe &&
            dq_out == $past(tx_word[2*BYTE_W-1:BYTE_W])));

    p_ready_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
        tx_ready != ck_p);

    p_hi_then_lo_r5: assert property (@(posedge clk2x) disable iff (!rst_n)
        ck_p |=> (!ck_p && dq_oe));

    p_idle_quiet_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
        !dq_oe |-> (!ck_p && dq_out == '0));

    p_rx_upper_r8: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_valid |-> rx_word[2*BYTE_W-1:BYTE_W] == $past(dq_in, 2));

    p_rx_valid_r9: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_en, 2));

    p_rx_hold_r10: assert property (@(posedge rx_clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));
endmodule

bind ddr8_link ddr8_link_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_word  (tx_word),
    .tx_ready (tx_ready),
    .ck_p     (ck_p),
    .ck_n     (ck_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rx_clk   (rx_clk),
    .rx_en    (rx_en),
    .dq_in    (dq_in),
    .rx_valid (rx_valid),
    .rx_word  (rx_word)
);

// File: tb/tb_ddr8_link.sv
module tb_ddr8_link;
    localparam int CLK_PERIOD = 10;
    localparam int TX_CYCLES  = 600;

    logic        clk2x = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_ready;
    logic        ck_p, ck_n, dq_oe;
    logic [7:0]  dq_out;
    logic        rx_clk = 1'b0;
    logic        rx_en = 1'b0;
    logic [7:0]  dq_in = '0;
    logic        rx_valid;
    logic [15:0] rx_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ddr8_link dut (
        .clk2x(clk2x), .rst_n(rst_n), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_ready(tx_ready), .ck_p(ck_p), .ck_n(ck_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .rx_clk(rx_clk), .rx_en(rx_en), .dq_in(dq_in),
        .rx_valid(rx_valid), .rx_word(rx_word)
    );

    always #(CLK_PERIOD/2) clk2x = ~clk2x;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit offer(input int i);
        case (i / 100)
            0: return (i % 3) == 0;
            1: return 1'b1;
            2: return (i % 2) == 1;
            3: return (i % 11) < 6;
            4: return 1'b1;
            default: return (i % 5) == 0;
        endcase
    endfunction

    // expected values for the receive side
    logic [7:0]  p_hi, p_lo;
    bit          p_en;
    logic [15:0] last_word;

    task automatic rx_cycle(input logic [7:0] hi, input logic [7:0] lo, input bit en);
        dq_in = hi;
        rx_en = en;
        #5 rx_clk = 1'b1;
        #2;
        chk("R9 rx_valid", {31'd0, rx_valid}, {31'd0, p_en});
        if (p_en) begin
            chk("R8 rx_word", {16'd0, rx_word}, {16'd0, p_hi, p_lo});
            last_word = {p_hi, p_lo};
        end else begin
            chk("R10 rx_word hold", {16'd0, rx_word}, {16'd0, last_word});
        end
        #3 dq_in = lo;
        #5 rx_clk = 1'b0;
        #5;
        p_hi = hi;
        p_lo = lo;
        p_en = en;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit          e_ck, e_oe, e_rdy, junk_prev;
        logic [7:0]  e_dq, lo_pend;

        // R1: reset values
        repeat (3) @(negedge clk2x);
        chk("R1 ck_p", {31'd0, ck_p}, 32'd0);
        chk("R1 ck_n", {31'd0, ck_n}, 32'd1);
        chk("R1 dq_oe", {31'd0, dq_oe}, 32'd0);
        chk("R1 dq_out", {24'd0, dq_out}, 32'd0);
        chk("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        chk("R1 rx_word", {16'd0, rx_word}, 32'd0);
        rst_n = 1'b1;

        e_ck = 0; e_oe = 0; e_rdy = 1; e_dq = '0; lo_pend = '0; junk_prev = 0;
        for (int i = 0; i < TX_CYCLES; i++) begin
            bit          v;
            logic [15:0] w;
            @(negedge clk2x);
            chk("R5 ck_p", {31'd0, ck_p}, {31'd0, e_ck});
            chk("R2 ck_n", {31'd0, ck_n}, {31'd0, !e_ck});
            chk("R6 dq_oe", {31'd0, dq_oe}, {31'd0, e_oe});
            chk("R4 tx_ready", {31'd0, tx_ready}, {31'd0, e_rdy});
            if (junk_prev)  chk("R7 dq_out", {24'd0, dq_out}, {24'd0, e_dq});
            else if (e_oe)  chk("R3 dq_out", {24'd0, dq_out}, {24'd0, e_dq});
            else            chk("R6 dq_out", {24'd0, dq_out}, {24'd0, e_dq});

            v = offer(i);
            w = 16'(i * 40503 + 4660);
            tx_valid = v;
            junk_prev = !(v && e_rdy);
            tx_word = junk_prev ? ~w : w;

            if (e_rdy && v) begin
                e_ck = 1; e_oe = 1; e_dq = w[15:8]; lo_pend = w[7:0]; e_rdy = 0;
            end else if (e_ck) begin
                e_ck = 0; e_oe = 1; e_dq = lo_pend; e_rdy = 1;
            end else begin
                e_ck = 0; e_oe = 0; e_dq = '0; e_rdy = 1;
            end
        end
        @(negedge clk2x);
        tx_valid = 1'b0;

        // receive sweep
        p_hi = '0; p_lo = '0; p_en = 0; last_word = '0;
        for (int i = 0; i < 256; i++) begin
            rx_cycle(8'(i), 8'(i * 37 + 11), (i % 7) != 3);
        end
        rx_cycle(8'hA5, 8'h3C, 1'b0);
        rx_cycle(8'h0F, 8'hF0, 1'b0);
        rx_cycle(8'h11, 8'h22, 1'b1);
        rx_cycle(8'h33, 8'h44, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule